// File: doc/BRIEF.md
# Fixed-Word SPI Master with Selectable Clock Mode

This block drives a serial peripheral bus as master, one fixed-width word at a time. A word offered on an AXI4-Stream sink is accepted while the master is idle. Chip select then goes low, and the word is shifted out MSB first on MOSI. At the same time MISO is shifted in, and the word received is returned on an AXI4-Stream source. Both streams run on the system clock. SCK is derived from the system clock by counting a parameterised number of cycles per half bit, so every MOSI change and every MISO sample falls on a known system-clock edge.

SCK idle level (CPOL) and sampling edge (CPHA) are compile-time parameters. CPHA = 0 samples on the rising SCK edge and CPHA = 1 on the falling edge, whatever the idle level. MOSI moves only on the other edge. The `rx_en` input is sampled when a word is accepted. When it is low, that transfer produces no word on the source, which suits write-only slaves.

The controller has five states. `ST_IDLE` has chip select high, SCK at its idle level and the sink ready. `ST_LEAD` holds chip select low for one half period before the first SCK edge. `ST_SHIFT` toggles SCK every half period. `ST_TRAIL` holds chip select low for one half period after the last edge. `ST_GAP` holds chip select high for one half period before the master returns to idle.

The transitions are:
- IDLE→LEAD on a sink handshake.
- LEAD→SHIFT on the first half-period tick, which is also SCK edge 0.
- SHIFT→TRAIL on the last of the 2·WORD_W edges.
- TRAIL→GAP on the next tick, when chip select rises and any received word is published.
- GAP→IDLE on the tick after that.

Top module: `spi_word_master`

## Requirements
- R1: After reset the outputs are `cs_n` = 1, `sck` = CPOL, `s_tready` = 1 and `m_tvalid` = 0.
- R2: A word is accepted only by a handshake (`s_tvalid` and `s_tready` both high). `s_tready` is high only in ST_IDLE and only while no received word is waiting on the source. While a received word waits, no new transfer starts.
- R3: Every SCK level lasts exactly HALF_CLKS system clocks. While `cs_n` is high, `sck` equals CPOL.
- R4: Each transfer has exactly 2·WORD_W SCK edges, so SCK is back at CPOL when the transfer ends.
- R5: The sampling edge is rising when CPHA = 0 and falling when CPHA = 1. MOSI never changes on a sampling edge. The slave sees the accepted word MSB first, one bit per sampling edge.
- R6: MISO is captured on each sampling edge, MSB first. After the transfer it appears as one word on `m_tdata`.
- R7: `cs_n` falls in the cycle after the accepting edge. The first SCK edge follows one half period later, and `cs_n` rises one half period after the last edge. `cs_n` stays low for (2·WORD_W+1)·HALF_CLKS cycles. Between back-to-back transfers it stays high for HALF_CLKS+1 cycles.
- R8: With `rx_en` high at acceptance, exactly one source beat is produced per transfer. `m_tvalid` and `m_tdata` stay stable until `m_tready` is high.
- R9: With `rx_en` low at acceptance, no source beat is produced, even if `rx_en` rises during the transfer.
- R10: `s_tready` stays low from acceptance until the master is back in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable, sampled at word acceptance |
| s_tdata | input | WORD_W | Word to transmit |
| s_tvalid | input | 1 | Sink valid |
| s_tready | output | 1 | Sink ready |
| m_tdata | output | WORD_W | Received word |
| m_tvalid | output | 1 | Source valid |
| m_tready | input | 1 | Source ready |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds four copies side by side, one for each CPOL/CPHA combination. All four use WORD_W = 8 and HALF_CLKS = 3 and share one set of stream stimulus. A short half period keeps each frame to 54 cycles, so patterns, back-pressure and back-to-back framing fit in a short run. An odd half period greater than one also exposes any off-by-one in the edge spacing or the chip-select lead and trail. Each copy talks to its own slave model, which returns a mode-dependent reply. This lets mixed-up sampling and launch edges, bit order errors and the rule that skips the first launch show up as data miscompares in the affected modes.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } spi_state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int HALF_CLKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF_CLKS > 1) begin : g_spacing
            // R3: half periods longer than one clock never produce adjacent ticks
            assert_half_spacing_R3: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sample,
    input  logic              advance,
    input  logic              miso_in,
    output logic              mosi_out,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
            rx_q <= '0;
        end else begin
            if (advance) begin
                tx_q <= tx_q << 1;
            end
            if (sample) begin
                rx_q <= (rx_q << 1) | WORD_W'(miso_in);
            end
        end
    end

    assign mosi_out = tx_q[WORD_W-1];
    assign rx_word  = rx_q;

    // R5: the line out only moves when a word is loaded or a launch edge advances it
    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(mosi_out));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int HALF_CLKS = 50,
    parameter bit CPOL      = 1'b0,
    parameter bit CPHA      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [WORD_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int   EDGES      = 2 * WORD_W;
    localparam int   EW         = $clog2(EDGES);
    localparam logic SAMPLE_LVL = (CPHA == 1'b0);

    spi_state_e state_q, state_d;

    logic              tick;
    logic              take;
    logic              edge_now;
    logic              last_edge;
    logic              smp;
    logic              adv;
    logic [EW-1:0]     edge_q;
    logic              sck_q;
    logic              cs_n_q;
    logic              rx_on_q;
    logic              m_tvalid_q;
    logic [WORD_W-1:0] m_tdata_q;
    logic [WORD_W-1:0] rx_word;

    spi_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    assign s_tready  = (state_q == ST_IDLE) && !m_tvalid_q;
    assign take      = s_tready && s_tvalid;
    assign edge_now  = tick && ((state_q == ST_LEAD) || (state_q == ST_SHIFT));
    assign last_edge = (edge_q == EW'(EDGES - 1));
    assign smp       = edge_now && ((~sck_q) == SAMPLE_LVL);
    assign adv       = edge_now && !smp && (edge_q != '0);

    spi_shift_unit #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .load_word (s_tdata),
        .sample    (smp),
        .advance   (adv),
        .miso_in   (miso),
        .mosi_out  (mosi),
        .rx_word   (rx_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take)                  state_d = ST_LEAD;
            ST_LEAD:  if (tick)                  state_d = ST_SHIFT;
            ST_SHIFT: if (edge_now && last_edge) state_d = ST_TRAIL;
            ST_TRAIL: if (tick)                  state_d = ST_GAP;
            ST_GAP:   if (tick)                  state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q     <= '0;
            sck_q      <= CPOL;
            cs_n_q     <= 1'b1;
            rx_on_q    <= 1'b0;
            m_tvalid_q <= 1'b0;
            m_tdata_q  <= '0;
        end else begin
            if (take) begin
                edge_q  <= '0;
                cs_n_q  <= 1'b0;
                rx_on_q <= rx_en;
            end else if (edge_now) begin
                edge_q <= edge_q + 1'b1;
                sck_q  <= ~sck_q;
            end
            if (m_tvalid_q && m_tready) begin
                m_tvalid_q <= 1'b0;
            end
            if ((state_q == ST_TRAIL) && tick) begin
                cs_n_q <= 1'b1;
                if (rx_on_q) begin
                    m_tvalid_q <= 1'b1;
                    m_tdata_q  <= rx_word;
                end
            end
        end
    end

    assign sck      = sck_q;
    assign cs_n     = cs_n_q;
    assign m_tvalid = m_tvalid_q;
    assign m_tdata  = m_tdata_q;

    // R3: clock parked at its idle level whenever the slave is deselected
    assert_idle_sck_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (sck == CPOL));

    // R10: no new word is taken while a frame is on the wire
    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !s_tready);

    // R7: handshake is followed by chip select in the next cycle
    assert_start_R7: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && s_tready) |=> !cs_n);

    // R8: an unaccepted received word stays put
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R2: a waiting received word blocks the sink
    assert_block_R2: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> !s_tready);

    // R4: an even edge count leaves the clock idle in the trail
    assert_even_edges_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRAIL) |-> (sck == CPOL));

    // R5: data line is steady across a sampling edge
    assert_sample_steady_R5: assert property (@(posedge clk) disable iff (rst)
        smp |=> $stable(mosi));

    // R9: a transfer taken with receive disabled publishes nothing
    assert_rx_off_R9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_TRAIL) && tick && !rx_on_q) |=> !m_tvalid);

endmodule

// File: tb/spi_word_master_tb.sv
module spi_slave_model #(
    parameter int W    = 8,
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic         clk,
    input  logic         sck,
    input  logic         mosi,
    input  logic         cs_n,
    input  logic [W-1:0] reply,
    output logic         miso,
    output logic [W-1:0] got,
    output int           frames,
    output int           edges,
    output int           low_cyc,
    output int           min_gap,
    output int           max_gap,
    output logic         mosi_bad,
    output logic         idle_bad
);
    logic prev_cs;
    logic prev_sck;
    logic prev_mosi;
    logic [W-1:0] txs;
    logic [W-1:0] rxs;
    int nbits;
    int gap;

    initial begin
        prev_cs = 1'b1; prev_sck = CPOL; prev_mosi = 1'b0;
        miso = 1'b0; got = '0; frames = 0; edges = 0; low_cyc = 0;
        min_gap = 0; max_gap = 0; mosi_bad = 1'b0; idle_bad = 1'b0;
        txs = '0; rxs = '0; nbits = 0; gap = 0;
    end

    always @(negedge clk) begin
        if (cs_n === 1'b1 && sck !== CPOL) idle_bad = 1'b1;
        if (prev_cs === 1'b1 && cs_n === 1'b0) begin
            txs = reply; miso = reply[W-1]; nbits = 0; rxs = '0;
            edges = 0; low_cyc = 1; gap = 0; min_gap = 1000000; max_gap = 0;
        end else if (cs_n === 1'b0) begin
            low_cyc++;
            gap++;
            if (sck !== prev_sck) begin
                edges++;
                if (gap < min_gap) min_gap = gap;
                if (gap > max_gap) max_gap = gap;
                gap = 0;
                if (sck == !CPHA) begin
                    if (mosi !== prev_mosi) mosi_bad = 1'b1;
                    rxs = (rxs << 1) | W'(mosi);
                    nbits++;
                end else if (nbits > 0 && nbits < W) begin
                    txs = txs << 1;
                    miso = txs[W-1];
                end
            end
        end else if (prev_cs === 1'b0 && cs_n === 1'b1) begin
            gap++;
            if (gap < min_gap) min_gap = gap;
            if (gap > max_gap) max_gap = gap;
            got = rxs;
            frames++;
        end
        prev_cs = cs_n; prev_sck = sck; prev_mosi = mosi;
    end
endmodule

module spi_word_master_tb;
    localparam int W     = 8;
    localparam int HALF  = 3;
    localparam int NM    = 4;
    localparam int FRAME = (2 * W + 2) * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b1;
    logic [W-1:0] s_tdata = '0;
    logic s_tvalid = 1'b0;
    logic m_tready = 1'b0;

    logic         str_a  [NM];
    logic [W-1:0] mtd_a  [NM];
    logic         mtv_a  [NM];
    logic         sck_a  [NM];
    logic         mosi_a [NM];
    logic         miso_a [NM];
    logic         cs_a   [NM];
    logic [W-1:0] reply_a[NM];
    logic [W-1:0] got_a  [NM];
    int frames_a[NM];
    int edges_a [NM];
    int low_a   [NM];
    int ming_a  [NM];
    int maxg_a  [NM];
    logic mbad_a[NM];
    logic ibad_a[NM];

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    generate
        for (genvar m = 0; m < NM; m++) begin : g_mode
            localparam bit MP = (m / 2) != 0;
            localparam bit MH = (m % 2) != 0;
            spi_word_master #(.WORD_W(W), .HALF_CLKS(HALF), .CPOL(MP), .CPHA(MH)) u_dut (
                .clk(clk), .rst(rst), .rx_en(rx_en),
                .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(str_a[m]),
                .m_tdata(mtd_a[m]), .m_tvalid(mtv_a[m]), .m_tready(m_tready),
                .sck(sck_a[m]), .mosi(mosi_a[m]), .miso(miso_a[m]), .cs_n(cs_a[m])
            );
            spi_slave_model #(.W(W), .CPOL(MP), .CPHA(MH)) u_slv (
                .clk(clk), .sck(sck_a[m]), .mosi(mosi_a[m]), .cs_n(cs_a[m]),
                .reply(reply_a[m]), .miso(miso_a[m]), .got(got_a[m]),
                .frames(frames_a[m]), .edges(edges_a[m]), .low_cyc(low_a[m]),
                .min_gap(ming_a[m]), .max_gap(maxg_a[m]),
                .mosi_bad(mbad_a[m]), .idle_bad(ibad_a[m])
            );
        end
    endgenerate

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [W-1:0] d);
        @(negedge clk);
        s_tdata = d;
        s_tvalid = 1'b1;
        while (str_a[0] !== 1'b1) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic t_reset();
        for (int m = 0; m < NM; m++) begin
            chk(cs_a[m] === 1'b1, "R1 cs_n after reset", cs_a[m], 1);
            chk(sck_a[m] === 1'((m / 2) != 0), "R1 sck idle after reset", sck_a[m], m / 2);
            chk(str_a[m] === 1'b1, "R1 s_tready after reset", str_a[m], 1);
            chk(mtv_a[m] === 1'b0, "R1 m_tvalid after reset", mtv_a[m], 0);
        end
    endtask

    task automatic t_xfer(input logic [W-1:0] d, input bit rxon);
        int f0[NM];
        for (int m = 0; m < NM; m++) begin
            reply_a[m] = d ^ W'(8'h3C + 8'h11 * m);
            f0[m] = frames_a[m];
        end
        rx_en = rxon;
        send_word(d);
        for (int m = 0; m < NM; m++)
            chk(cs_a[m] === 1'b0, "R7 cs_n low one cycle after accept", cs_a[m], 0);
        if (!rxon) rx_en = 1'b1;
        repeat (FRAME + 4) @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            chk(frames_a[m] == f0[m] + 1, "R7 one frame per word", frames_a[m], f0[m] + 1);
            chk(got_a[m] == d, "R5 slave received word", got_a[m], d);
            chk(edges_a[m] == 2 * W, "R4 sck edge count", edges_a[m], 2 * W);
            chk(low_a[m] == (2 * W + 1) * HALF, "R7 cs_n low cycles", low_a[m], (2 * W + 1) * HALF);
            chk(ming_a[m] == HALF && maxg_a[m] == HALF, "R3 half period", ming_a[m], HALF);
            chk(mbad_a[m] === 1'b0, "R5 mosi moved on sample edge", mbad_a[m], 0);
            chk(ibad_a[m] === 1'b0, "R3 sck not idle while deselected", ibad_a[m], 0);
            if (rxon) begin
                chk(mtv_a[m] === 1'b1, "R8 m_tvalid after frame", mtv_a[m], 1);
                chk(mtd_a[m] == reply_a[m], "R6 received word", mtd_a[m], reply_a[m]);
                chk(str_a[m] === 1'b0, "R2 sink blocked while word waits", str_a[m], 0);
            end else begin
                chk(mtv_a[m] === 1'b0, "R9 no beat with receive off", mtv_a[m], 0);
                chk(str_a[m] === 1'b1, "R9 sink ready after write-only frame", str_a[m], 1);
            end
        end
        if (rxon) begin
            repeat (3) @(negedge clk);
            for (int m = 0; m < NM; m++) begin
                chk(mtv_a[m] === 1'b1, "R8 m_tvalid held", mtv_a[m], 1);
                chk(mtd_a[m] == reply_a[m], "R8 m_tdata held", mtd_a[m], reply_a[m]);
            end
            m_tready = 1'b1;
            @(negedge clk);
            m_tready = 1'b0;
            for (int m = 0; m < NM; m++) begin
                chk(mtv_a[m] === 1'b0, "R8 beat consumed once", mtv_a[m], 0);
                chk(str_a[m] === 1'b1, "R2 sink ready after consume", str_a[m], 1);
            end
        end
    endtask

    task automatic t_patterns();
        t_xfer(8'hA5, 1'b1);
        t_xfer(8'h00, 1'b1);
        t_xfer(8'hFF, 1'b1);
        t_xfer(8'h01, 1'b1);
        t_xfer(8'h80, 1'b1);
    endtask

    task automatic t_rx_off();
        t_xfer(8'h5A, 1'b0);
        t_xfer(8'hC3, 1'b0);
    endtask

    task automatic t_busy_and_block();
        int f0;
        for (int m = 0; m < NM; m++) reply_a[m] = 8'h69;
        rx_en = 1'b1;
        send_word(8'h96);
        repeat (HALF * 5) @(negedge clk);
        for (int m = 0; m < NM; m++)
            chk(str_a[m] === 1'b0, "R10 sink not ready mid-frame", str_a[m], 0);
        repeat (FRAME) @(negedge clk);
        f0 = frames_a[0];
        s_tdata = 8'h3C;
        s_tvalid = 1'b1;
        repeat (2 * FRAME) @(negedge clk);
        chk(frames_a[0] == f0, "R2 no start while word waits", frames_a[0], f0);
        for (int m = 0; m < NM; m++)
            chk(cs_a[m] === 1'b1, "R2 cs_n stays high while word waits", cs_a[m], 1);
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
        @(negedge clk);
        s_tvalid = 1'b0;
        for (int m = 0; m < NM; m++)
            chk(cs_a[m] === 1'b0, "R2 start once source drained", cs_a[m], 0);
        repeat (FRAME + 4) @(negedge clk);
        for (int m = 0; m < NM; m++)
            chk(got_a[m] == 8'h3C, "R5 word after back-pressure", got_a[m], 8'h3C);
        m_tready = 1'b1;
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    task automatic t_back_to_back();
        int hi;
        rx_en = 1'b0;
        @(negedge clk);
        s_tdata = 8'h71;
        s_tvalid = 1'b1;
        while (cs_a[0] !== 1'b0) @(negedge clk);
        s_tdata = 8'h8E;
        while (cs_a[0] !== 1'b1) @(negedge clk);
        hi = 0;
        while (cs_a[0] !== 1'b0) begin
            hi++;
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        chk(hi == HALF + 1, "R7 deselect gap between frames", hi, HALF + 1);
        repeat (FRAME + 4) @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            chk(got_a[m] == 8'h8E, "R5 second back-to-back word", got_a[m], 8'h8E);
            chk(mtv_a[m] === 1'b0, "R9 no beat in write-only stream", mtv_a[m], 0);
        end
        rx_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < NM; m++) reply_a[m] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_rx_off();
        t_busy_and_block();
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule